// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block is the mode sequencer of a single-wire bus transceiver that also carries an on-chip supply regulator. It decides, every clock cycle, which of five operating modes the device is in: powered-off, fail-safe, active, quiet (listen-only with the regulator still on) and dormant (regulator off). It acts on digitized supply comparators, the host's enable and transmit pins, the digitized bus level and a wake strobe from a separate wake detector. From the mode it produces registered controls for the regulator, the reset line to the host, the bus driver, the bus termination and the two host-side data pins.

Every interval (reset hold, enable settling, mode-select window, undervoltage debounce) is a parameter in clock cycles. All asynchronous pin inputs pass through two-flop synchronizers. The wake strobe is taken as already synchronous. Battery loss wins over every other event. Regulator undervoltage wins over any enable-driven change.

When the host lowers enable in active mode, the block opens a mode-select window and samples the transmit pin at its end: high means quiet, low means dormant. In fail-safe, both host pins act as outputs and report why the device is there.

Top module: `lmc_top`

## Requirements
- R1: While the synchronized battery-low input is high, the mode becomes powered-off whatever else is applied. In powered-off, all seven outputs are 0: reg_en_o, rst_n_o, tx_en_o, term_en_o, rxd_drv_o, txd_oe_o and txd_drv_o.
- R2: When battery-on rises in powered-off, the block enters fail-safe with reg_en_o=1. It holds rst_n_o=0 for RST_CYC cycles, and during that time no mode change is taken, even with enable high.
- R3: In fail-safe, once the reset hold has ended, enable held high for NORM_CYC consecutive cycles moves the block to active. Only in active is tx_en_o=1, and only there does rxd_drv_o follow the synchronized bus level.
- R4: A falling enable in active mode opens a window of SEL_CYC cycles in which tx_en_o=0. At the end of the window, transmit high selects quiet and transmit low selects dormant. Enable returning high inside the window cancels the window and keeps the block in active mode.
- R5: In quiet mode: reg_en_o=1, rst_n_o=1, term_en_o=0. In dormant mode: reg_en_o=0, rst_n_o=0, term_en_o=0.
- R6: A regulator undervoltage held for DEB_CYC synchronized cycles, in active or quiet mode, drives rst_n_o low and forces fail-safe with the supply cause. A shorter undervoltage pulse has no effect.
- R7: A wake strobe in quiet or dormant mode moves the block to fail-safe with the wake cause, turning the regulator and the termination on. Coming from dormant, the reset hold restarts. A wake strobe in active mode is ignored.
- R8: In fail-safe: txd_oe_o=1 and rxd_drv_o=0. txd_drv_o is 0 for the wake cause (transmit low, receive low) and 1 for the supply cause (transmit high, receive low).
- R9: In quiet mode: rxd_drv_o=1 and txd_oe_o=0. In dormant mode: rxd_drv_o=0 and txd_oe_o=0.
- R10: If enable is high when a wake from dormant restores the regulator, the block reaches active by itself once the reset hold and the enable settling delay have both elapsed.
- R11: In quiet mode, enable held high for NORM_CYC cycles moves the block to active.
- R12: Regulator undervoltage overrides a high enable, and battery-low overrides both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vbat_on_i | input | 1 | Battery above its switch-on threshold (asynchronous) |
| vbat_low_i | input | 1 | Battery below its switch-off threshold (asynchronous) |
| vcc_uv_i | input | 1 | Regulator output below its undervoltage threshold (asynchronous) |
| en_i | input | 1 | Host enable pin |
| txd_i | input | 1 | Host transmit pin as input |
| bus_rx_i | input | 1 | Digitized bus level, 1 = recessive |
| wake_i | input | 1 | One-cycle synchronous wake strobe |
| reg_en_o | output | 1 | Regulator enable |
| rst_n_o | output | 1 | Host reset, active low |
| tx_en_o | output | 1 | Bus driver enable |
| term_en_o | output | 1 | Bus termination enable |
| rxd_drv_o | output | 1 | Value driven on the receive pin |
| txd_oe_o | output | 1 | Transmit pin output enable |
| txd_drv_o | output | 1 | Value driven on the transmit pin when enabled |

## Verification
On every cycle, the assertions check:
- that battery-low forces powered-off;
- that the driver is off outside active mode and during the select window;
- that dormant mode keeps the regulator, reset and termination low;
- that a debounced undervoltage ends active or quiet mode;
- the pin roles in fail-safe and quiet modes.

Only the bench scenarios show the timing relations and the ordering cases:
- that the reset hold really spans its full length while enable is high;
- that a short undervoltage glitch is filtered out;
- that a window cancelled by enable keeps active mode;
- that the wake-cause and supply-cause encodings differ;
- that a dormant wake with enable high reaches active without further host action.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  typedef enum logic [2:0] {
    MD_OFF     = 3'd0,
    MD_SAFE    = 3'd1,
    MD_RUN     = 3'd2,
    MD_QUIET   = 3'd3,
    MD_DORMANT = 3'd4
  } mode_e;

  typedef enum logic {
    CAUSE_SUPPLY = 1'b0,
    CAUSE_WAKE   = 1'b1
  } cause_e;
endpackage

// File: rtl/lmc_sync.sv
module lmc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/lmc_timer.sv
module lmc_timer #(
  parameter int CW   = 8,
  parameter int INIT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= CW'(INIT);
    else if (load)
      cnt <= load_val;
    else if (tick && (cnt != '0))
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/lmc_fsm.sv
module lmc_fsm
  import lmc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic vbat_on_s,
  input  logic vbat_low_s,
  input  logic uv_flt,
  input  logic en_s,
  input  logic txd_s,
  input  logic bus_s,
  input  logic wake_i,
  input  logic rst_zero,
  input  logic norm_zero,
  input  logic sel_zero,
  output logic rst_load,
  output logic norm_load,
  output logic sel_load,
  output logic reg_en_o,
  output logic rst_n_o,
  output logic tx_en_o,
  output logic term_en_o,
  output logic rxd_drv_o,
  output logic txd_oe_o,
  output logic txd_drv_o
);
  mode_e  state, state_nx;
  cause_e cause, cause_nx;
  logic   en_q;
  logic   win, win_nx;
  logic   go_run;
  logic   win_done;
  logic   powered;

  assign rst_load  = (state == MD_OFF) || (state == MD_DORMANT) || uv_flt;
  assign norm_load = !((state == MD_SAFE) || (state == MD_QUIET)) || !en_s ||
                     !rst_zero || uv_flt;
  assign sel_load  = (state == MD_RUN) && en_q && !en_s && !win;
  assign go_run    = en_s && norm_zero && rst_zero && !uv_flt && !norm_load;
  assign win_done  = win && !en_s && sel_zero;
  assign powered   = (state == MD_SAFE) || (state == MD_RUN) || (state == MD_QUIET);

  always_comb begin
    win_nx = win;
    if (state != MD_RUN)   win_nx = 1'b0;
    else if (sel_load)     win_nx = 1'b1;
    else if (win && en_s)  win_nx = 1'b0;
  end

  always_comb begin
    state_nx = state;
    cause_nx = cause;
    if (vbat_low_s) begin
      state_nx = MD_OFF;
    end else begin
      case (state)
        MD_OFF: begin
          if (vbat_on_s) begin
            state_nx = MD_SAFE;
            cause_nx = CAUSE_SUPPLY;
          end
        end
        MD_SAFE: begin
          if (go_run) state_nx = MD_RUN;
        end
        MD_RUN: begin
          if (uv_flt) begin
            state_nx = MD_SAFE;
            cause_nx = CAUSE_SUPPLY;
          end else if (win_done) begin
            state_nx = txd_s ? MD_QUIET : MD_DORMANT;
          end
        end
        MD_QUIET: begin
          if (uv_flt) begin
            state_nx = MD_SAFE;
            cause_nx = CAUSE_SUPPLY;
          end else if (wake_i) begin
            state_nx = MD_SAFE;
            cause_nx = CAUSE_WAKE;
          end else if (go_run) begin
            state_nx = MD_RUN;
          end
        end
        MD_DORMANT: begin
          if (wake_i) begin
            state_nx = MD_SAFE;
            cause_nx = CAUSE_WAKE;
          end
        end
        default: state_nx = MD_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= MD_OFF;
      cause <= CAUSE_SUPPLY;
      en_q  <= 1'b0;
      win   <= 1'b0;
    end else begin
      state <= state_nx;
      cause <= cause_nx;
      en_q  <= en_s;
      win   <= win_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_en_o  <= 1'b0;
      rst_n_o   <= 1'b0;
      tx_en_o   <= 1'b0;
      term_en_o <= 1'b0;
      rxd_drv_o <= 1'b0;
      txd_oe_o  <= 1'b0;
      txd_drv_o <= 1'b0;
    end else begin
      reg_en_o  <= powered;
      rst_n_o   <= powered && rst_zero && !uv_flt;
      tx_en_o   <= (state == MD_RUN) && !win;
      term_en_o <= (state == MD_SAFE) || (state == MD_RUN);
      txd_oe_o  <= (state == MD_SAFE);
      txd_drv_o <= (state == MD_SAFE) && (cause == CAUSE_SUPPLY);
      case (state)
        MD_RUN:   rxd_drv_o <= bus_s;
        MD_QUIET: rxd_drv_o <= 1'b1;
        default:  rxd_drv_o <= 1'b0;
      endcase
    end
  end

  assert_unpowered_R1: assert property (@(posedge clk) disable iff (rst)
    vbat_low_s |=> (state == MD_OFF));

  assert_reset_hold_R2: assert property (@(posedge clk) disable iff (rst)
    ((state == MD_SAFE) && !rst_zero) |=> (state != MD_RUN));

  assert_tx_only_run_R3: assert property (@(posedge clk) disable iff (rst)
    (state != MD_RUN) |=> !tx_en_o);

  assert_window_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    win |=> !tx_en_o);

  assert_dormant_off_R5: assert property (@(posedge clk) disable iff (rst)
    (state == MD_DORMANT) |=> (!reg_en_o && !rst_n_o && !term_en_o));

  assert_uv_exit_R6: assert property (@(posedge clk) disable iff (rst)
    (uv_flt && !vbat_low_s && ((state == MD_RUN) || (state == MD_QUIET)))
      |=> (state == MD_SAFE));

  assert_safe_pins_R8: assert property (@(posedge clk) disable iff (rst)
    (state == MD_SAFE) |=> (txd_oe_o && !rxd_drv_o));

  assert_quiet_pins_R9: assert property (@(posedge clk) disable iff (rst)
    (state == MD_QUIET) |=> (rxd_drv_o && !txd_oe_o));
endmodule

// File: rtl/lmc_top.sv
module lmc_top #(
  parameter int RST_CYC  = 1000000,
  parameter int NORM_CYC = 2500,
  parameter int SEL_CYC  = 800,
  parameter int DEB_CYC  = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic vbat_on_i,
  input  logic vbat_low_i,
  input  logic vcc_uv_i,
  input  logic en_i,
  input  logic txd_i,
  input  logic bus_rx_i,
  input  logic wake_i,
  output logic reg_en_o,
  output logic rst_n_o,
  output logic tx_en_o,
  output logic term_en_o,
  output logic rxd_drv_o,
  output logic txd_oe_o,
  output logic txd_drv_o
);
  localparam int RST_W  = $clog2(RST_CYC + 1);
  localparam int NORM_W = $clog2(NORM_CYC + 1);
  localparam int SEL_W  = $clog2(SEL_CYC + 1);
  localparam int DEB_W  = $clog2(DEB_CYC + 1);
  localparam int NSYNC  = 6;

  logic [NSYNC-1:0] pins_s;
  logic vbat_on_s, vbat_low_s, uv_s, en_s, txd_s, bus_s;
  logic deb_zero, uv_flt;
  logic rst_zero, norm_zero, sel_zero;
  logic rst_load, norm_load, sel_load;

  lmc_sync #(.W(NSYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bus_rx_i, txd_i, en_i, vcc_uv_i, vbat_low_i, vbat_on_i}),
    .q   (pins_s)
  );

  assign {bus_s, txd_s, en_s, uv_s, vbat_low_s, vbat_on_s} = pins_s;

  lmc_timer #(.CW(DEB_W), .INIT(DEB_CYC)) u_deb (
    .clk (clk), .rst (rst), .load (!uv_s), .load_val (DEB_W'(DEB_CYC)),
    .tick (uv_s), .zero (deb_zero)
  );
  assign uv_flt = uv_s && deb_zero;

  lmc_timer #(.CW(RST_W), .INIT(RST_CYC)) u_rst_tmr (
    .clk (clk), .rst (rst), .load (rst_load), .load_val (RST_W'(RST_CYC)),
    .tick (1'b1), .zero (rst_zero)
  );

  lmc_timer #(.CW(NORM_W), .INIT(NORM_CYC)) u_norm_tmr (
    .clk (clk), .rst (rst), .load (norm_load), .load_val (NORM_W'(NORM_CYC)),
    .tick (1'b1), .zero (norm_zero)
  );

  lmc_timer #(.CW(SEL_W), .INIT(SEL_CYC)) u_sel_tmr (
    .clk (clk), .rst (rst), .load (sel_load), .load_val (SEL_W'(SEL_CYC)),
    .tick (1'b1), .zero (sel_zero)
  );

  lmc_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .vbat_on_s  (vbat_on_s),
    .vbat_low_s (vbat_low_s),
    .uv_flt     (uv_flt),
    .en_s       (en_s),
    .txd_s      (txd_s),
    .bus_s      (bus_s),
    .wake_i     (wake_i),
    .rst_zero   (rst_zero),
    .norm_zero  (norm_zero),
    .sel_zero   (sel_zero),
    .rst_load   (rst_load),
    .norm_load  (norm_load),
    .sel_load   (sel_load),
    .reg_en_o   (reg_en_o),
    .rst_n_o    (rst_n_o),
    .tx_en_o    (tx_en_o),
    .term_en_o  (term_en_o),
    .rxd_drv_o  (rxd_drv_o),
    .txd_oe_o   (txd_oe_o),
    .txd_drv_o  (txd_drv_o)
  );
endmodule

// File: tb/lmc_top_tb.sv
module lmc_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vbat_on = 1'b0, vbat_low = 1'b0, vcc_uv = 1'b0;
  logic en = 1'b0, txd = 1'b1, bus = 1'b1, wake = 1'b0;
  logic reg_en, rst_n, tx_en, term_en, rxd_drv, txd_oe, txd_drv;

  always #2 clk = ~clk;

  lmc_top #(.RST_CYC(40), .NORM_CYC(6), .SEL_CYC(10), .DEB_CYC(5)) u_dut (
    .clk (clk), .rst (rst), .vbat_on_i (vbat_on), .vbat_low_i (vbat_low),
    .vcc_uv_i (vcc_uv), .en_i (en), .txd_i (txd), .bus_rx_i (bus),
    .wake_i (wake), .reg_en_o (reg_en), .rst_n_o (rst_n), .tx_en_o (tx_en),
    .term_en_o (term_en), .rxd_drv_o (rxd_drv), .txd_oe_o (txd_oe),
    .txd_drv_o (txd_drv)
  );

  // {reg_en, rst_n, tx_en, term_en, rxd, txd_oe, txd_drv}
  localparam logic [6:0] V_OFF      = 7'b0000000;
  localparam logic [6:0] V_SAFE_SUP = 7'b1001011;
  localparam logic [6:0] V_SAFE_OK  = 7'b1101011;
  localparam logic [6:0] V_WAKE_RST = 7'b1001010;
  localparam logic [6:0] V_WAKE_OK  = 7'b1101010;
  localparam logic [6:0] V_RUN_H    = 7'b1111100;
  localparam logic [6:0] V_RUN_L    = 7'b1111000;
  localparam logic [6:0] V_WINDOW   = 7'b1101100;
  localparam logic [6:0] V_QUIET    = 7'b1100100;
  localparam logic [6:0] V_DORMANT  = 7'b0000000;

  typedef struct {
    logic [6:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic [6:0] exp);
    item_t it;
    it.exp = exp;
    it.tag = tag;
    q.push_back(it);
    #1;
  endtask

  task automatic pulse_wake();
    wake = 1'b1;
    cyc(1);
    wake = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      item_t it;
      logic [6:0] act;
      wait (q.size() > 0);
      it  = q.pop_front();
      act = {reg_en, rst_n, tx_en, term_en, rxd_drv, txd_oe, txd_drv};
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(2);
    expect_out("R1 reset state off", V_OFF);

    // power-up with enable already high
    en = 1'b1;
    vbat_on = 1'b1;
    cyc(6);
    expect_out("R2 fail-safe entry, reset low", V_SAFE_SUP);
    cyc(20);
    expect_out("R2 enable ignored during reset hold", V_SAFE_SUP);
    cyc(40);
    expect_out("R3 active after reset and settling", V_RUN_H);
    bus = 1'b0;
    cyc(4);
    expect_out("R3 receive follows bus", V_RUN_L);
    bus = 1'b1;

    // cancelled select window
    en = 1'b0;
    cyc(5);
    expect_out("R4 driver off in select window", V_WINDOW);
    en = 1'b1;
    cyc(10);
    expect_out("R4 window cancelled stays active", V_RUN_H);

    // go quiet
    txd = 1'b1;
    en = 1'b0;
    cyc(20);
    expect_out("R4 R5 R9 quiet mode", V_QUIET);

    // wake from quiet
    pulse_wake();
    cyc(4);
    expect_out("R7 R8 wake from quiet to fail-safe", V_WAKE_OK);
    en = 1'b1;
    cyc(15);
    expect_out("R3 fail-safe to active", V_RUN_H);

    // quiet back to active
    en = 1'b0;
    cyc(20);
    expect_out("R9 quiet again", V_QUIET);
    en = 1'b1;
    cyc(15);
    expect_out("R11 quiet to active on enable", V_RUN_H);

    // wake in active ignored
    pulse_wake();
    cyc(4);
    expect_out("R7 wake ignored in active", V_RUN_H);

    // short undervoltage glitch
    vcc_uv = 1'b1;
    cyc(3);
    vcc_uv = 1'b0;
    cyc(6);
    expect_out("R6 short undervoltage filtered", V_RUN_H);

    // debounced undervoltage with enable high
    vcc_uv = 1'b1;
    cyc(12);
    expect_out("R6 R12 undervoltage forces fail-safe", V_SAFE_SUP);
    vcc_uv = 1'b0;
    cyc(80);
    expect_out("R12 active again after recovery", V_RUN_H);

    // dormant
    txd = 1'b0;
    en = 1'b0;
    cyc(20);
    expect_out("R5 R9 dormant mode", V_DORMANT);

    // wake from dormant, enable raised afterwards
    pulse_wake();
    cyc(6);
    expect_out("R7 R8 dormant wake restarts reset", V_WAKE_RST);
    en = 1'b1;
    txd = 1'b1;
    cyc(80);
    expect_out("R10 automatic active after dormant wake", V_RUN_H);

    // battery loss overrides everything
    vbat_low = 1'b1;
    vcc_uv = 1'b1;
    cyc(6);
    expect_out("R1 R12 battery low wins", V_OFF);
    vbat_low = 1'b0;
    vcc_uv = 1'b0;
    cyc(6);
    expect_out("R2 re-entry to fail-safe", V_SAFE_SUP);

    cyc(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule